// File: doc/BRIEF.md
# Streaming DFT Multiply-Accumulate Engine Fed by a Sine/Cosine Pipeline

This block computes a 32-point discrete Fourier transform of real-valued samples. The host first fills a small local sample store through a simple write port. It then pulses a start command. From that point the block drives one twiddle angle per clock into an external fixed-latency sine/cosine pipeline, with no idle cycles, for all N×N (bin, sample) pairs. Each sample is held back by the same latency as the pipeline, so it meets its own cosine and sine at the multipliers. Two wide accumulators build the real and imaginary sums of every bin.

When all bins are complete, the block writes them out over a result memory port. It leaves one idle cycle between writes, as the memory needs. It then raises an interrupt, which stays high until the host acknowledges it. A start command that arrives while a job is in progress is dropped.

Top module: `dft_mac_engine`

## Requirements
- R1: After reset, `irq`, `cs_valid` and `res_we` are all 0.
- R2: A `start` pulse sampled while idle makes `cs_valid` high for exactly N×N consecutive cycles with no gap. The first of these is the cycle after the edge that sampled `start`.
- R3: In issue cycle j (counted from 0), bin k = j / N and sample n = j mod N. `cs_angle` then carries the 5-bit value (−k·n) mod 32 in its top bits and zeros below. The value is in units of 1/32 of a full turn.
- R4: `cs_cos`/`cs_sin` are sampled LAT cycles after the angle that produced them. For bin k, `res_re` equals Σ x[n]·cos and `res_im` equals Σ x[n]·sin, exact at full width. Samples and twiddles are signed two's complement.
- R5: Both accumulators restart at the first product of every bin. No bin and no earlier job leaks into a later result.
- R6: The N results are written at addresses 0 to N−1 in ascending order. The first write falls N×N+LAT+1 cycles after the edge that accepted `start`.
- R7: Two result writes never fall on consecutive cycles. Successive writes are exactly two cycles apart.
- R8: `irq` rises in the cycle after the final result write. It holds until `irq_ack` is sampled high, and it is low in the following cycle.
- R9: A `start` pulse during a running job has no effect. The issue sequence, the write timing and the results are unchanged.
- R10: With every sample at full-scale negative (−32768) and twiddles up to ±16384, the sums do not overflow. Bin 0 reads −2^34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_we | input | 1 | Sample store write enable |
| smp_addr | input | 5 | Sample index to write |
| smp_data | input | 16 | Signed sample value |
| start | input | 1 | Start-of-job pulse |
| cs_angle | output | 16 | Angle to the sine/cosine pipeline, fraction of a turn |
| cs_valid | output | 1 | Angle is valid this cycle |
| cs_cos | input | 16 | Cosine from the pipeline, signed, 1.0 = 16384 |
| cs_sin | input | 16 | Sine from the pipeline, signed, 1.0 = 16384 |
| res_we | output | 1 | Result memory write strobe |
| res_addr | output | 5 | Bin index being written |
| res_re | output | 37 | Real part of the bin |
| res_im | output | 37 | Imaginary part of the bin |
| irq | output | 1 | Job-complete interrupt |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
All timing is measured from the edge that accepts `start`, taken as cycle −1:
- The angles are valid in cycles 0 to 1023.
- The last product is accumulated in cycle 1023+LAT.
- The first write is due in cycle 1041, and write i in cycle 1041+2i.
- `irq` is due in cycle 1104.
- After an acknowledge, `irq` is due low one cycle later.

The bench counts cycles from the accepting edge and samples every output at the falling edge. Each check is made against the exact cycle number above, never against a window. The sine/cosine model in the bench is a register chain of the same LAT stages, fed from its own rounded table.

// File: rtl/dft_pkg.sv
package dft_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_WRITE = 2'd3
  } dft_state_e;
endpackage

// File: rtl/dft_angle_seq.sv
module dft_angle_seq #(
  parameter int N     = 32,
  parameter int ANG_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go,
  output logic                       valid,
  output logic                       last,
  output logic [$clog2(N)-1:0]       bin_k,
  output logic [$clog2(N)-1:0]       smp_n,
  output logic [2*$clog2(N)-1:0]     idx,
  output logic [ANG_W-1:0]           angle
);
  localparam int IW    = $clog2(N);
  localparam int CNT_W = 2 * IW;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N * N - 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [IW-1:0]    kn;
  logic [IW-1:0]    neg_kn;

  always_comb begin
    run_d = run_q;
    idx_d = idx_q;
    if (go) begin
      run_d = 1'b1;
      idx_d = '0;
    end else if (run_q) begin
      if (idx_q == LAST_IDX) begin
        run_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      idx_q <= '0;
    end else begin
      run_q <= run_d;
      idx_q <= idx_d;
    end
  end

  assign bin_k  = idx_q[CNT_W-1:IW];
  assign smp_n  = idx_q[IW-1:0];
  assign kn     = bin_k * smp_n;
  assign neg_kn = IW'(0) - kn;
  assign valid  = run_q;
  assign last   = run_q && (idx_q == LAST_IDX);
  assign idx    = idx_q;
  assign angle  = {neg_kn, {(ANG_W - IW){1'b0}}};
endmodule

// File: rtl/dft_tag_pipe.sv
module dft_tag_pipe #(
  parameter int W = 8,
  parameter int D = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [D];

  for (genvar g = 0; g < D; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[D-1];
endmodule

// File: rtl/dft_mac.sv
module dft_mac #(
  parameter int N  = 32,
  parameter int SW = 16,
  parameter int TW = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              t_valid,
  input  logic                              t_first,
  input  logic                              t_last,
  input  logic [$clog2(N)-1:0]              t_k,
  input  logic signed [SW-1:0]              x,
  input  logic signed [TW-1:0]              cos_in,
  input  logic signed [TW-1:0]              sin_in,
  input  logic [$clog2(N)-1:0]              rd_addr,
  output logic [SW+TW+$clog2(N)-1:0]        rd_re,
  output logic [SW+TW+$clog2(N)-1:0]        rd_im,
  output logic                              done
);
  localparam int IW    = $clog2(N);
  localparam int PW    = SW + TW;
  localparam int ACC_W = PW + IW;

  logic signed [PW-1:0]    prod_re, prod_im;
  logic signed [ACC_W-1:0] ext_re, ext_im;
  logic signed [ACC_W-1:0] acc_re_q, acc_im_q, acc_re_d, acc_im_d;
  logic                    done_q, done_d;
  logic                    store_en;
  logic [ACC_W-1:0]        bin_re [N];
  logic [ACC_W-1:0]        bin_im [N];

  assign prod_re = x * cos_in;
  assign prod_im = x * sin_in;
  assign ext_re  = {{IW{prod_re[PW-1]}}, prod_re};
  assign ext_im  = {{IW{prod_im[PW-1]}}, prod_im};

  always_comb begin
    acc_re_d = acc_re_q;
    acc_im_d = acc_im_q;
    if (t_valid) begin
      if (t_first) begin
        acc_re_d = ext_re;
        acc_im_d = ext_im;
      end else begin
        acc_re_d = acc_re_q + ext_re;
        acc_im_d = acc_im_q + ext_im;
      end
    end
  end

  assign store_en = t_valid && t_last;
  assign done_d   = store_en && (t_k == IW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re_q <= '0;
      acc_im_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (t_valid) begin
        acc_re_q <= acc_re_d;
        acc_im_q <= acc_im_d;
      end
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (store_en) begin
      bin_re[t_k] <= acc_re_d;
      bin_im[t_k] <= acc_im_d;
    end
  end

  assign rd_re = bin_re[rd_addr];
  assign rd_im = bin_im[rd_addr];
  assign done  = done_q;
endmodule

// File: rtl/dft_writeback.sv
module dft_writeback #(
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  output logic                 we,
  output logic [$clog2(N)-1:0] addr,
  output logic                 done
);
  localparam int IW = $clog2(N);

  logic          active_q, active_d;
  logic          gap_q, gap_d;
  logic [IW-1:0] addr_q, addr_d;

  assign we   = active_q && !gap_q;
  assign done = we && (addr_q == IW'(N - 1));

  always_comb begin
    active_d = active_q;
    gap_d    = gap_q;
    addr_d   = addr_q;
    if (go) begin
      active_d = 1'b1;
      gap_d    = 1'b0;
      addr_d   = '0;
    end else if (active_q) begin
      if (done) begin
        active_d = 1'b0;
      end else if (gap_q) begin
        gap_d  = 1'b0;
        addr_d = addr_q + 1'b1;
      end else begin
        gap_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      gap_q    <= 1'b0;
      addr_q   <= '0;
    end else begin
      active_q <= active_d;
      gap_q    <= gap_d;
      addr_q   <= addr_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/dft_mac_engine.sv
module dft_mac_engine
  import dft_pkg::*;
#(
  parameter int N     = 32,
  parameter int SW    = 16,
  parameter int TW    = 16,
  parameter int ANG_W = 16,
  parameter int LAT   = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           smp_we,
  input  logic [$clog2(N)-1:0]           smp_addr,
  input  logic [SW-1:0]                  smp_data,
  input  logic                           start,
  output logic [ANG_W-1:0]               cs_angle,
  output logic                           cs_valid,
  input  logic [TW-1:0]                  cs_cos,
  input  logic [TW-1:0]                  cs_sin,
  output logic                           res_we,
  output logic [$clog2(N)-1:0]           res_addr,
  output logic [SW+TW+$clog2(N)-1:0]     res_re,
  output logic [SW+TW+$clog2(N)-1:0]     res_im,
  output logic                           irq,
  input  logic                           irq_ack
);
  localparam int IW    = $clog2(N);
  localparam int CNT_W = 2 * IW;
  localparam int TAG_W = 3 + 2 * IW;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // sample store
  logic [SW-1:0] smp_mem [N];

  always_ff @(posedge clk) begin
    if (smp_we) smp_mem[smp_addr] <= smp_data;
  end

  // controller
  dft_state_e state_q, state_d;
  logic       irq_q, irq_d;
  logic       issue_go, wb_go;
  logic       seq_valid, seq_last;
  logic [IW-1:0]    seq_k, seq_n;
  logic [CNT_W-1:0] seq_idx;
  logic       mac_done, wb_done;

  assign issue_go = (state_q == ST_IDLE) && start;
  assign wb_go    = (state_q == ST_DRAIN) && mac_done;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start)    state_d = ST_ISSUE;
      ST_ISSUE: if (seq_last) state_d = ST_DRAIN;
      ST_DRAIN: if (mac_done) state_d = ST_WRITE;
      ST_WRITE: if (wb_done)  state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    irq_d = irq_q;
    if (wb_done)      irq_d = 1'b1;
    else if (irq_ack) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  // angle issue
  dft_angle_seq #(.N(N), .ANG_W(ANG_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_i_n),
    .go    (issue_go),
    .valid (seq_valid),
    .last  (seq_last),
    .bin_k (seq_k),
    .smp_n (seq_n),
    .idx   (seq_idx),
    .angle (cs_angle)
  );
  assign cs_valid = seq_valid;

  // tag alignment with the sine/cosine latency
  logic [TAG_W-1:0] tag_in, tag_out;
  logic             t_valid, t_first, t_last;
  logic [IW-1:0]    t_k, t_n;

  assign tag_in = {seq_valid,
                   seq_valid && (seq_n == '0),
                   seq_valid && (seq_n == IW'(N - 1)),
                   seq_k, seq_n};

  dft_tag_pipe #(.W(TAG_W), .D(LAT)) u_tag (
    .clk   (clk),
    .rst_n (rst_i_n),
    .din   (tag_in),
    .dout  (tag_out)
  );
  assign {t_valid, t_first, t_last, t_k, t_n} = tag_out;

  // multiply-accumulate
  logic [IW-1:0] wb_addr;

  dft_mac #(.N(N), .SW(SW), .TW(TW)) u_mac (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .t_valid (t_valid),
    .t_first (t_first),
    .t_last  (t_last),
    .t_k     (t_k),
    .x       (smp_mem[t_n]),
    .cos_in  (cs_cos),
    .sin_in  (cs_sin),
    .rd_addr (wb_addr),
    .rd_re   (res_re),
    .rd_im   (res_im),
    .done    (mac_done)
  );

  // paced writeback
  dft_writeback #(.N(N)) u_wb (
    .clk   (clk),
    .rst_n (rst_i_n),
    .go    (wb_go),
    .we    (res_we),
    .addr  (wb_addr),
    .done  (wb_done)
  );
  assign res_addr = wb_addr;
  assign irq      = irq_q;
endmodule

// File: rtl/dft_mac_engine_chk.sv
module dft_mac_engine_chk #(
  parameter int N = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       irq_ack,
  input logic                       cs_valid,
  input logic                       res_we,
  input logic [$clog2(N)-1:0]       res_addr,
  input logic                       irq,
  input logic                       seq_last,
  input logic [2*$clog2(N)-1:0]     seq_idx,
  input logic                       wb_done
);
  localparam int IW    = $clog2(N);
  localparam int CNT_W = 2 * IW;

  // R2: the issue index steps by one every cycle until the last pair
  p_gapless_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_valid && !seq_last) |=> (cs_valid && (seq_idx == CNT_W'($past(seq_idx) + 1'b1))));

  // R9: start during issue does not restart or stop the sequence
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_valid && start && !seq_last) |=> (cs_valid && (seq_idx != '0)));

  // R7: writes never back to back
  p_spaced_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> !res_we);

  // R6: writeback only after issuing has ended
  p_wb_after_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> !cs_valid);

  // R8: interrupt held until acknowledged
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  // R8: acknowledge clears the interrupt
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !wb_done) |=> !irq);

  // R8: interrupt rises right after the final write
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(res_we) && ($past(res_addr) == IW'(N - 1))));
endmodule

bind dft_mac_engine dft_mac_engine_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .irq_ack  (irq_ack),
  .cs_valid (cs_valid),
  .res_we   (res_we),
  .res_addr (res_addr),
  .irq      (irq),
  .seq_last (seq_last),
  .seq_idx  (seq_idx),
  .wb_done  (wb_done)
);

// File: tb/test_dft_mac_engine.sv
module test_dft_mac_engine;
  localparam int  N      = 32;
  localparam int  SW     = 16;
  localparam int  TW     = 16;
  localparam int  ANG_W  = 16;
  localparam int  LAT    = 16;
  localparam int  IW     = 5;
  localparam int  ACC_W  = SW + TW + IW;
  localparam time PERIOD = 10ns;
  localparam int  FIRST_WR = N * N + LAT + 1;

  logic             clk, rst_n;
  logic             smp_we;
  logic [IW-1:0]    smp_addr;
  logic [SW-1:0]    smp_data;
  logic             start;
  logic [ANG_W-1:0] cs_angle;
  logic             cs_valid;
  logic [TW-1:0]    cs_cos, cs_sin;
  logic             res_we;
  logic [IW-1:0]    res_addr;
  logic [ACC_W-1:0] res_re, res_im;
  logic             irq, irq_ack;

  int checks, failures;
  int ctab [N];
  int stab [N];
  int xs   [N];
  longint exp_re [N];
  longint exp_im [N];

  dft_mac_engine #(.N(N), .SW(SW), .TW(TW), .ANG_W(ANG_W), .LAT(LAT)) i_dft_mac_engine (
    .clk(clk), .rst_n(rst_n), .smp_we(smp_we), .smp_addr(smp_addr), .smp_data(smp_data),
    .start(start), .cs_angle(cs_angle), .cs_valid(cs_valid), .cs_cos(cs_cos), .cs_sin(cs_sin),
    .res_we(res_we), .res_addr(res_addr), .res_re(res_re), .res_im(res_im),
    .irq(irq), .irq_ack(irq_ack)
  );

  initial clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  // sine/cosine model: LAT register stages, table indexed by top angle bits
  logic [TW-1:0] pc [LAT];
  logic [TW-1:0] ps [LAT];
  always_ff @(posedge clk) begin
    pc[0] <= TW'(ctab[cs_angle[ANG_W-1 -: IW]]);
    ps[0] <= TW'(stab[cs_angle[ANG_W-1 -: IW]]);
    for (int i = 1; i < LAT; i++) begin
      pc[i] <= pc[i-1];
      ps[i] <= ps[i-1];
    end
  end
  assign cs_cos = pc[LAT-1];
  assign cs_sin = ps[LAT-1];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_and_expect();
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      smp_we   = 1'b1;
      smp_addr = IW'(n);
      smp_data = SW'(xs[n]);
    end
    @(negedge clk);
    smp_we = 1'b0;
    for (int k = 0; k < N; k++) begin
      exp_re[k] = 0;
      exp_im[k] = 0;
      for (int n = 0; n < N; n++) begin
        int a;
        a = (N - ((k * n) % N)) % N;
        exp_re[k] += longint'(xs[n]) * longint'(ctab[a]);
        exp_im[k] += longint'(xs[n]) * longint'(stab[a]);
      end
    end
  endtask

  // runs one job; cycle t = 0 is the cycle after the accepting edge
  task automatic run_job(input string tag, input bit inject_start);
    int  vbad, abad, wcount, wbad, first_wr, last_wr, prev_wr, irq_t;
    vbad = 0; abad = 0; wcount = 0; wbad = 0;
    first_wr = -1; last_wr = -1; prev_wr = -100; irq_t = -1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < FIRST_WR + 2 * N + 4; t++) begin
      if (cs_valid != (t < N * N)) vbad++;
      if (cs_valid) begin
        int k, n, ea;
        k  = t / N;
        n  = t % N;
        ea = (N - ((k * n) % N)) % N;
        if (cs_angle != {IW'(ea), 11'b0}) abad++;
      end
      if (res_we) begin
        if (first_wr < 0) first_wr = t;
        if (t - prev_wr != 2 && prev_wr >= 0) wbad++;
        if (t - prev_wr == 1) wbad++;
        prev_wr = t;
        last_wr = t;
        if (int'(res_addr) != wcount) begin
          check(1'b0, "R6", {tag, " write order"}, res_addr, wcount);
        end else begin
          check(longint'($signed(res_re)) == exp_re[wcount], "R4",
                {tag, " real bin"}, longint'($signed(res_re)), exp_re[wcount]);
          check(longint'($signed(res_im)) == exp_im[wcount], "R4",
                {tag, " imag bin"}, longint'($signed(res_im)), exp_im[wcount]);
        end
        wcount++;
      end
      if (irq && irq_t < 0) irq_t = t;
      if (inject_start) start = (t == 400);
      @(negedge clk);
    end
    start = 1'b0;
    check(vbad == 0, "R2", {tag, " gapless valid window"}, vbad, 0);
    check(abad == 0, "R3", {tag, " angle encoding"}, abad, 0);
    check(wcount == N, "R6", {tag, " write count"}, wcount, N);
    check(first_wr == FIRST_WR, "R6", {tag, " first write cycle"}, first_wr, FIRST_WR);
    check(wbad == 0, "R7", {tag, " write spacing"}, wbad, 0);
    check(irq_t == last_wr + 1, "R8", {tag, " irq cycle"}, irq_t, last_wr + 1);
    if (inject_start) check(first_wr == FIRST_WR && wcount == N, "R9",
                            {tag, " start while busy ignored"}, first_wr, FIRST_WR);
    // interrupt hold and acknowledge
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R8", {tag, " irq held"}, irq, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(irq == 1'b0, "R8", {tag, " irq cleared by ack"}, irq, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0d17;
    checks = 0; failures = 0;
    for (int i = 0; i < N; i++) begin
      ctab[i] = $rtoi($floor(16384.0 * $cos(2.0 * 3.14159265358979 * i / N) + 0.5));
      stab[i] = $rtoi($floor(16384.0 * $sin(2.0 * 3.14159265358979 * i / N) + 0.5));
    end
    rst_n = 1'b0; smp_we = 1'b0; smp_addr = '0; smp_data = '0;
    start = 1'b0; irq_ack = 1'b0;
    repeat (4) @(negedge clk);
    check(irq == 1'b0 && cs_valid == 1'b0 && res_we == 1'b0, "R1", "reset outputs",
          {irq, cs_valid, res_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(irq == 1'b0 && cs_valid == 1'b0 && res_we == 1'b0, "R1", "idle after reset",
          {irq, cs_valid, res_we}, 0);

    // random job
    void'($urandom(seed));
    for (int n = 0; n < N; n++) xs[n] = int'($signed(16'($urandom())));
    load_and_expect();
    run_job("random1", 1'b0);

    // impulse (R4 directed)
    for (int n = 0; n < N; n++) xs[n] = (n == 0) ? 1000 : 0;
    load_and_expect();
    run_job("impulse", 1'b0);
    check(exp_re[7] == 64'd16384000, "R4", "impulse model sanity", exp_re[7], 16384000);

    // full-scale negative with start injected mid-job (R10, R9)
    for (int n = 0; n < N; n++) xs[n] = -32768;
    load_and_expect();
    check(exp_re[0] == -64'sd17179869184, "R10", "full-scale bin 0 expected",
          exp_re[0], -64'sd17179869184);
    run_job("fullscale_R10", 1'b1);

    // second random job: nothing left over from earlier jobs (R5)
    for (int n = 0; n < N; n++) xs[n] = int'($signed(16'($urandom())));
    load_and_expect();
    run_job("random2_R5", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule